// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter

This block holds two timer/counter channels, channel 0 and channel 1. Each channel keeps a 16-bit count split into a high byte and a low byte. A shared configuration register gives each channel three settings. The first is a gate enable that lets an external level pin start and stop counting. The second picks the count source: every clock cycle, or falling edges on an external event pin. The third selects one of four counting modes: 13-bit, 16-bit, 8-bit with auto-reload, and split.

In split mode, channel 0 becomes two independent 8-bit counters. Its high byte then counts clock cycles under channel 1's run bit. A channel 1 set to split mode stops and keeps its count.

Software works through a flat byte-wide register port, where writes are synchronous and reads are combinational. A control register holds one run bit and one sticky overflow flag per channel. The flags also appear as output pins, for an interrupt controller outside this block.

Top module: `tmr_pair`

## Requirements
- R1: After synchronous reset, every mapped register reads 0x00 and both `ovf_flag` bits are 0.
- R2: The register map is: control at 0x88, configuration at 0x89, channel 0 low/high count at 0x8A/0x8C, channel 1 low/high count at 0x8B/0x8D. Configuration bits [7:4] belong to channel 1 and [3:0] to channel 0; within each nibble bit 3 is gate, bit 2 is external-source and bits 1:0 the mode. Control bit 4 is run 0, bit 5 flag 0, bit 6 run 1, bit 7 flag 1, and bits 3:0 read 0. Unmapped addresses read 0x00. Every mapped bit reads back what was written when no count changes it.
- R3: A channel advances only while its run bit is 1. When its gate bit is 1, the synchronized gate pin must also be high.
- R4: With the external-source bit set, a channel advances once per falling edge of its event pin. The pin passes through a 2-stage synchronizer before edge detection, so a transition needs three clock edges to change the count.
- R5: Mode 00 counts a 13-bit value of the high byte over low bits [4:0]. Low bits [7:5] are left unchanged. Wrapping from 0x1FFF to 0 sets the channel's flag.
- R6: Mode 01 counts the full 16-bit value. Wrapping from 0xFFFF sets the flag.
- R7: Mode 10 counts the low byte only. On an advance from 0xFF, the low byte is loaded from the high byte and the flag sets. The high byte does not change.
- R8: In mode 11, channel 0's low byte counts under channel 0's own gate, source and run settings, and its wrap sets flag 0. Channel 0's high byte counts every cycle that run 1 is set, and its wrap sets flag 1.
- R9: Channel 1 in mode 11 holds both count bytes.
- R10: A flag stays set until software writes 0 to it, and writing 1 sets it. A hardware wrap in the same cycle as a clearing write leaves the flag set.
- R11: A write to either count byte of a channel replaces that byte. That channel makes no advance and raises no wrap in the same cycle.
- R12: While channel 0 is in mode 11, a wrap of channel 1 does not set flag 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the internal count source |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| gate_pin | input | 2 | Asynchronous gate level per channel |
| count_pin | input | 2 | Asynchronous event input per channel |
| ovf_flag | output | 2 | Sticky overflow flags, channel index per bit |

## Verification
The bench builds the block with its default parameters: a 2-stage pin synchronizer and the standard address map. With these, the bench's pipeline model has the same depth as the design, so it can predict the exact cycle on which an event-pin edge takes effect. Because every count byte is 8 bits wide, the bench can preload values a few steps below each wrap point. That brings the 13-bit, 16-bit, reload and split wraps within a handful of cycles. It also makes same-cycle clashes between writes, flag clears and wraps frequent during the random phase.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int TMR_BYTE_W = 8;
    localparam int TMR_PRE_W  = 5;
    localparam int TMR_NARROW = TMR_BYTE_W + TMR_PRE_W;

    typedef enum logic [1:0] {
        MODE_13     = 2'b00,
        MODE_16     = 2'b01,
        MODE_RELOAD = 2'b10,
        MODE_SPLIT  = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic      gate;
        logic      ext;
        tmr_mode_e mode;
    } tmr_cfg_t;

    typedef struct packed {
        logic [TMR_BYTE_W-1:0] hi;
        logic [TMR_BYTE_W-1:0] lo;
    } tmr_cnt_t;

    typedef struct packed {
        tmr_cnt_t cnt;
        logic     wrap;
    } tmr_step_t;

    // One advance of a non-split channel in the given mode.
    function automatic tmr_step_t tmr_advance(tmr_mode_e m, tmr_cnt_t c);
        tmr_step_t                 r;
        logic [TMR_NARROW-1:0]     v13;
        logic [2*TMR_BYTE_W-1:0]   v16;
        r   = '{cnt: c, wrap: 1'b0};
        v13 = {c.hi, c.lo[TMR_PRE_W-1:0]};
        v16 = {c.hi, c.lo};
        case (m)
            MODE_13: begin
                r.wrap   = &v13;
                v13      = v13 + 1'b1;
                r.cnt.hi = v13[TMR_NARROW-1:TMR_PRE_W];
                r.cnt.lo = {c.lo[TMR_BYTE_W-1:TMR_PRE_W], v13[TMR_PRE_W-1:0]};
            end
            MODE_16: begin
                r.wrap = &v16;
                v16    = v16 + 1'b1;
                r.cnt  = v16;
            end
            MODE_RELOAD: begin
                r.wrap   = &c.lo;
                r.cnt.lo = r.wrap ? c.hi : c.lo + 1'b1;
            end
            default: r.wrap = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/tmr_pin_sync.sv
`timescale 1ns/1ps
module tmr_pin_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync
);
    logic [STAGES-1:0] shreg [WIDTH];

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) shreg[p] <= '0;
            else if (STAGES == 1) shreg[p] <= pin_async[p];
            else shreg[p] <= {shreg[p][STAGES-2:0], pin_async[p]};
        end
        assign pin_sync[p] = shreg[p][STAGES-1];
    end
endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
    import tmr_pkg::*;
#(
    parameter bit IS_T0 = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  tmr_cfg_t              cfg,
    input  logic                  run,
    input  logic                  gate_lvl,
    input  logic                  ext_lvl,
    input  logic                  hi_run,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [TMR_BYTE_W-1:0] wdata,
    output tmr_cnt_t              cnt_o,
    output logic                  wrap_lo_o,
    output logic                  wrap_hi_o
);
    tmr_cnt_t  cnt_q, cnt_d;
    tmr_step_t step;
    logic      ext_prev;
    logic      ext_fall;
    logic      adv;

    assign ext_fall = ext_prev & ~ext_lvl;
    assign adv      = run & (~cfg.gate | gate_lvl) & (~cfg.ext | ext_fall);

    always_comb begin
        cnt_d     = cnt_q;
        wrap_lo_o = 1'b0;
        wrap_hi_o = 1'b0;
        step      = '0;
        if (wr_lo || wr_hi) begin
            if (wr_lo) cnt_d.lo = wdata;
            if (wr_hi) cnt_d.hi = wdata;
        end else if (cfg.mode == MODE_SPLIT) begin
            if (IS_T0) begin
                if (adv) begin
                    cnt_d.lo  = cnt_q.lo + 1'b1;
                    wrap_lo_o = &cnt_q.lo;
                end
                if (hi_run) begin
                    cnt_d.hi  = cnt_q.hi + 1'b1;
                    wrap_hi_o = &cnt_q.hi;
                end
            end
        end else if (adv) begin
            step      = tmr_advance(cfg.mode, cnt_q);
            cnt_d     = step.cnt;
            wrap_lo_o = step.wrap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            ext_prev <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            ext_prev <= ext_lvl;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_pair.sv
`timescale 1ns/1ps
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h88,
    parameter logic [ADDR_W-1:0] CFG_ADDR    = 8'h89,
    parameter logic [ADDR_W-1:0] TL0_ADDR    = 8'h8A,
    parameter logic [ADDR_W-1:0] TL1_ADDR    = 8'h8B,
    parameter logic [ADDR_W-1:0] TH0_ADDR    = 8'h8C,
    parameter logic [ADDR_W-1:0] TH1_ADDR    = 8'h8D
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [TMR_BYTE_W-1:0] reg_wdata,
    output logic [TMR_BYTE_W-1:0] reg_rdata,
    input  logic [1:0]            gate_pin,
    input  logic [1:0]            count_pin,
    output logic [1:0]            ovf_flag
);
    localparam int NCH = 2;

    tmr_cfg_t [NCH-1:0] cfg_q;
    logic     [NCH-1:0] run_q, flag_q, flag_set;
    logic     [NCH-1:0] gate_lvl, ext_lvl;
    logic     [NCH-1:0] wr_lo, wr_hi, wrap_lo, wrap_hi;
    tmr_cnt_t [NCH-1:0] cnt_w;
    logic               ctrl_we, cfg_we, split0;

    tmr_pin_sync #(.WIDTH(2*NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async ({count_pin, gate_pin}),
        .pin_sync  ({ext_lvl, gate_lvl})
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] LO_A = (i == 0) ? TL0_ADDR : TL1_ADDR;
        localparam logic [ADDR_W-1:0] HI_A = (i == 0) ? TH0_ADDR : TH1_ADDR;
        assign wr_lo[i] = reg_we && (reg_addr == LO_A);
        assign wr_hi[i] = reg_we && (reg_addr == HI_A);
        tmr_chan #(.IS_T0(i == 0)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .cfg       (cfg_q[i]),
            .run       (run_q[i]),
            .gate_lvl  (gate_lvl[i]),
            .ext_lvl   (ext_lvl[i]),
            .hi_run    ((i == 0) ? run_q[1] : 1'b0),
            .wr_lo     (wr_lo[i]),
            .wr_hi     (wr_hi[i]),
            .wdata     (reg_wdata),
            .cnt_o     (cnt_w[i]),
            .wrap_lo_o (wrap_lo[i]),
            .wrap_hi_o (wrap_hi[i])
        );
    end

    assign ctrl_we = reg_we && (reg_addr == CTRL_ADDR);
    assign cfg_we  = reg_we && (reg_addr == CFG_ADDR);
    assign split0  = (cfg_q[0].mode == MODE_SPLIT);

    // Channel 1 flag source moves to channel 0's high byte in split mode.
    assign flag_set[0] = wrap_lo[0];
    assign flag_set[1] = (split0 ? wrap_hi[0] : wrap_lo[1]) | wrap_hi[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            if (cfg_we) cfg_q <= reg_wdata;
            if (ctrl_we) run_q <= {reg_wdata[6], reg_wdata[4]};
            flag_q <= (ctrl_we ? {reg_wdata[7], reg_wdata[5]} : flag_q) | flag_set;
        end
    end

    always_comb begin
        case (reg_addr)
            CTRL_ADDR: reg_rdata = {flag_q[1], run_q[1], flag_q[0], run_q[0], 4'b0000};
            CFG_ADDR:  reg_rdata = cfg_q;
            TL0_ADDR:  reg_rdata = cnt_w[0].lo;
            TH0_ADDR:  reg_rdata = cnt_w[0].hi;
            TL1_ADDR:  reg_rdata = cnt_w[1].lo;
            TH1_ADDR:  reg_rdata = cnt_w[1].hi;
            default:   reg_rdata = '0;
        endcase
    end

    assign ovf_flag = flag_q;
endmodule

// File: rtl/tmr_pair_chk.sv
`timescale 1ns/1ps
module tmr_pair_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h88,
    parameter logic [ADDR_W-1:0] TL0_ADDR  = 8'h8A,
    parameter logic [ADDR_W-1:0] TL1_ADDR  = 8'h8B,
    parameter logic [ADDR_W-1:0] TH0_ADDR  = 8'h8C,
    parameter logic [ADDR_W-1:0] TH1_ADDR  = 8'h8D
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        mode_bits,
    input logic [31:0]       cnts,
    input logic [1:0]        flags,
    input logic [1:0]        gate_lvl
);
    logic wr_t0, wr_t1, ctrl_we;
    assign wr_t0   = reg_we && (reg_addr == TL0_ADDR || reg_addr == TH0_ADDR);
    assign wr_t1   = reg_we && (reg_addr == TL1_ADDR || reg_addr == TH1_ADDR);
    assign ctrl_we = reg_we && (reg_addr == CTRL_ADDR);

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (cnts == 32'd0 && flags == 2'b00));

    // R3
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_bits[3] && !gate_lvl[0] && mode_bits[1:0] != 2'b11 && !wr_t0) |=> $stable(cnts[15:0]));

    // R5
    upper_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_bits[1:0] == 2'b00 && !wr_t0) |=> $stable(cnts[7:5]));

    // R7
    reload_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_bits[1:0] == 2'b10 && !wr_t0) |=> $stable(cnts[15:8]));

    // R7
    reload_val_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_bits[1:0] == 2'b10 && cnts[7:0] == 8'hFF && !wr_t0)
        |=> (cnts[7:0] == $past(cnts[15:8]) || cnts[7:0] == 8'hFF));

    // R9
    t1_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_bits[5:4] == 2'b11 && !wr_t1) |=> $stable(cnts[31:16]));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags[0] && !ctrl_we) |=> flags[0]);

    // R10
    flag1_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags[1] && !ctrl_we) |=> flags[1]);

    // R11
    wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == TL0_ADDR) |=> cnts[7:0] == $past(reg_wdata));
endmodule

bind tmr_pair tmr_pair_chk #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .TL0_ADDR(TL0_ADDR),
    .TL1_ADDR(TL1_ADDR), .TH0_ADDR(TH0_ADDR), .TH1_ADDR(TH1_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mode_bits (cfg_q),
    .cnts      (cnt_w),
    .flags     (flag_q),
    .gate_lvl  (gate_lvl)
);

// File: tb/tb_tmr_pair.sv
`timescale 1ns/1ps
module tb_tmr_pair;
    localparam int SYNC = 2;
    localparam logic [7:0] A_CTRL = 8'h88, A_CFG = 8'h89, A_TL0 = 8'h8A,
                           A_TL1 = 8'h8B, A_TH0 = 8'h8C, A_TH1 = 8'h8D;

    logic       clk = 1'b0, rst = 1'b1, reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
    logic [1:0] gate_pin = 2'b00, count_pin = 2'b00, ovf_flag;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0;

    tmr_pair #(.SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gate_pin(gate_pin),
        .count_pin(count_pin), .ovf_flag(ovf_flag)
    );

    always #2.5 clk = ~clk;

    // ---------------- reference model ----------------
    logic [15:0]     m_cnt [2];
    logic [7:0]      m_cfg;
    logic [1:0]      m_run, m_flag;
    logic [SYNC-1:0] g_sh [2];
    logic [SYNC-1:0] c_sh [2];
    logic [1:0]      c_prev;

    function automatic logic [16:0] adv(logic [1:0] m, logic [15:0] c);
        logic [12:0] v;
        case (m)
            2'b00: begin
                v = {c[15:8], c[4:0]};
                return {&v, v + 13'd1} == 0 ? 17'd0 :
                       {&v, 8'(({c[15:8], c[4:0]} + 13'd1) >> 5), c[7:5], 5'(c[4:0] + 5'd1)};
            end
            2'b01:   return {&c, c + 16'd1};
            2'b10:   return (c[7:0] == 8'hFF) ? {1'b1, c[15:8], c[15:8]} : {1'b0, c[15:8], c[7:0] + 8'd1};
            default: return {1'b0, c};
        endcase
    endfunction

    always @(posedge clk) begin
        logic [1:0]  en, fall, g;
        logic [15:0] n0, n1;
        logic [16:0] r;
        logic        s0, w1, hw, t0w, t1w;
        if (rst) begin
            m_cnt[0] = 0; m_cnt[1] = 0; m_cfg = 0; m_run = 0; m_flag = 0;
            g_sh[0] = 0; g_sh[1] = 0; c_sh[0] = 0; c_sh[1] = 0; c_prev = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                g[i]    = g_sh[i][SYNC-1];
                fall[i] = c_prev[i] && !c_sh[i][SYNC-1];
                en[i]   = m_run[i] && (!m_cfg[4*i+3] || g[i]) && (!m_cfg[4*i+2] || fall[i]);
            end
            n0 = m_cnt[0]; n1 = m_cnt[1]; s0 = 0; w1 = 0; hw = 0;
            t0w = reg_we && (reg_addr == A_TL0 || reg_addr == A_TH0);
            t1w = reg_we && (reg_addr == A_TL1 || reg_addr == A_TH1);
            if (t0w) begin
                if (reg_addr == A_TL0) n0[7:0] = reg_wdata; else n0[15:8] = reg_wdata;
            end else if (m_cfg[1:0] == 2'b11) begin
                if (en[0]) begin n0[7:0] = m_cnt[0][7:0] + 8'd1; s0 = (m_cnt[0][7:0] == 8'hFF); end
                if (m_run[1]) begin n0[15:8] = m_cnt[0][15:8] + 8'd1; hw = (m_cnt[0][15:8] == 8'hFF); end
            end else if (en[0]) begin
                r = adv(m_cfg[1:0], m_cnt[0]); n0 = r[15:0]; s0 = r[16];
            end
            if (t1w) begin
                if (reg_addr == A_TL1) n1[7:0] = reg_wdata; else n1[15:8] = reg_wdata;
            end else if (m_cfg[5:4] != 2'b11 && en[1]) begin
                r = adv(m_cfg[5:4], m_cnt[1]); n1 = r[15:0]; w1 = r[16];
            end
            if (reg_we && reg_addr == A_CTRL) begin
                m_run  = {reg_wdata[6], reg_wdata[4]};
                m_flag = {reg_wdata[7], reg_wdata[5]};
            end
            m_flag[0] = m_flag[0] | s0;
            m_flag[1] = m_flag[1] | ((m_cfg[1:0] == 2'b11) ? hw : w1);
            if (reg_we && reg_addr == A_CFG) m_cfg = reg_wdata;
            m_cnt[0] = n0; m_cnt[1] = n1;
            for (int i = 0; i < 2; i++) begin
                c_prev[i] = c_sh[i][SYNC-1];
                c_sh[i]   = (SYNC == 1) ? SYNC'(count_pin[i]) : {c_sh[i][SYNC-2:0], count_pin[i]};
                g_sh[i]   = (SYNC == 1) ? SYNC'(gate_pin[i])  : {g_sh[i][SYNC-2:0], gate_pin[i]};
            end
        end
    end

    function automatic logic [7:0] m_read(logic [7:0] a);
        case (a)
            A_CTRL:  return {m_flag[1], m_run[1], m_flag[0], m_run[0], 4'b0000};
            A_CFG:   return m_cfg;
            A_TL0:   return m_cnt[0][7:0];
            A_TH0:   return m_cnt[0][15:8];
            A_TL1:   return m_cnt[1][7:0];
            A_TH1:   return m_cnt[1][15:8];
            default: return 8'h00;
        endcase
    endfunction

    // ---------------- bench helpers ----------------
    task automatic cmp(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic rd(string req, logic [7:0] a);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #1;
        cmp(req, reg_rdata, m_read(a));
    endtask

    task automatic check_all(string req);
        rd(req, A_CTRL); rd(req, A_CFG); rd(req, A_TL0);
        rd(req, A_TH0);  rd(req, A_TL1); rd(req, A_TH1);
        rd(req, 8'h80);
        #0.2 cmp({req, " flag pins"}, {6'd0, ovf_flag}, {6'd0, m_flag});
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] addrs [6];
        addrs = '{A_CTRL, A_CFG, A_TL0, A_TH0, A_TL1, A_TH1};
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset");

        wr(A_CFG, 8'hA5); wr(A_TL0, 8'h3C); wr(A_TH0, 8'hC3);
        wr(A_TL1, 8'h5A); wr(A_TH1, 8'hA5); wr(A_CTRL, 8'hA0);
        check_all("R2 readback");
        wr(A_CTRL, 8'h00); wr(A_CFG, 8'h00);

        // R5: 13-bit wrap with TL[7:5] = 111
        wr(A_TH0, 8'hFF); wr(A_TL0, 8'hFC); wr(A_CTRL, 8'h10);
        wait_cyc(6); check_all("R5 13-bit");
        wr(A_CTRL, 8'h00);

        // R6: 16-bit wrap
        wr(A_CFG, 8'h01); wr(A_TH0, 8'hFF); wr(A_TL0, 8'hFD); wr(A_CTRL, 8'h10);
        wait_cyc(5); check_all("R6 16-bit");
        wr(A_CTRL, 8'h00);

        // R7: auto-reload
        wr(A_CFG, 8'h02); wr(A_TH0, 8'hF0); wr(A_TL0, 8'hFE); wr(A_CTRL, 8'h10);
        wait_cyc(30); check_all("R7 reload");
        wr(A_CTRL, 8'h00);

        // R8: split channel 0
        wr(A_CFG, 8'h03); wr(A_TH0, 8'hFE); wr(A_TL0, 8'hFB); wr(A_CTRL, 8'h50);
        wait_cyc(8); check_all("R8 split");
        wr(A_CTRL, 8'h00);

        // R9: channel 1 halted
        wr(A_CFG, 8'h31); wr(A_TH1, 8'h12); wr(A_TL1, 8'h34); wr(A_CTRL, 8'h40);
        wait_cyc(10); check_all("R9 halt");
        wr(A_CTRL, 8'h00);

        // R12: channel 1 wraps while channel 0 split
        wr(A_CFG, 8'h13); wr(A_TH1, 8'hFF); wr(A_TL1, 8'hFE); wr(A_TH0, 8'h00);
        wr(A_CTRL, 8'h40);
        wait_cyc(5); check_all("R12 flag source");
        wr(A_CTRL, 8'h00);

        // R3: gate
        wr(A_CFG, 8'h09); wr(A_TH0, 8'h00); wr(A_TL0, 8'h00); wr(A_CTRL, 8'h10);
        gate_pin = 2'b00; wait_cyc(10); check_all("R3 gate low");
        gate_pin = 2'b01; wait_cyc(10); check_all("R3 gate high");
        gate_pin = 2'b00; wr(A_CTRL, 8'h00);

        // R4: external events
        wr(A_CFG, 8'h05); wr(A_TL0, 8'h00); wr(A_CTRL, 8'h10);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk) count_pin[0] = 1'b1; wait_cyc(4);
            count_pin[0] = 1'b0; wait_cyc(4);
        end
        check_all("R4 events");
        wait_cyc(12); check_all("R4 idle");
        wr(A_CTRL, 8'h00);

        // R10: software set and clear
        wr(A_CTRL, 8'hA0); check_all("R10 set");
        wr(A_CTRL, 8'h00); check_all("R10 clear");

        // R11: write while counting
        wr(A_CFG, 8'h01); wr(A_CTRL, 8'h10);
        wait_cyc(3); wr(A_TL0, 8'h77); check_all("R11 write priority");

        // random phase
        for (int it = 0; it < 4000; it++) begin
            @(negedge clk);
            reg_we = (($urandom % 6) == 0);
            reg_addr = addrs[$urandom % 6];
            reg_wdata = (($urandom % 2) == 0) ? (8'hF8 | 8'($urandom % 8)) : 8'($urandom);
            if (($urandom % 4) == 0) gate_pin = 2'($urandom);
            if (($urandom % 3) == 0) count_pin = 2'($urandom);
            if ((it % 50) == 49) begin
                @(posedge clk); #1 reg_we = 1'b0;
                check_all("RND R5 R6 R7 R8 R10 R11");
            end
        end
        reg_we = 1'b0;
        check_all("final");
        done = 1'b1;
        summary();
    end
endmodule